// File: doc/BRIEF.md
# Hierarchical Memory and Peripheral Bus Splitter

This block sits between a processor's 64-bit Wishbone classic-cycle master port and the rest of the chip. The wide bus is decoded into only three first-level destinations: on-chip block RAM, external DRAM, and one shared peripheral leg. The two memory destinations are reached combinationally, so their request fields, acknowledge and read data pass straight through. Addresses that match no destination are answered by the block itself.

The peripheral leg is registered before any further decoding. This keeps the wide bus free of the peripheral fan-out. The registered request is narrowed to a 32-bit access. A 64-bit access whose byte selects cover both 32-bit halves becomes two sequential narrow cycles, low half first. A second decoder then picks one of several 32-bit peripherals from an index field of the address. Read results are steered back onto the 64-bit lanes. While the peripheral leg works on a request, the master sees stall, and it receives a single registered acknowledge when the request is finished.

Top module: `bus_splitter`

## Requirements
- R1: The first-level target is chosen by byte-address bits [31:30]. 00 selects block RAM (`bram_cyc`/`bram_stb`). 01 selects DRAM (`dram_cyc`/`dram_stb`). 11 selects the peripheral leg. 10 is unmapped. At most one destination is strobed, and a destination that was not selected is never strobed.
- R2: For block RAM and DRAM, `mem_adr`, `mem_sel`, `mem_we` and `mem_wdat` equal the master's fields in the same cycle. The target's `*_ack` and `*_rdat` reach `m_ack`/`m_rdat` in the same cycle, with no added wait.
- R3: An access to the unmapped region is acknowledged one clock after it is presented, for exactly one cycle, with read data of all ones. No target is strobed.
- R4: A peripheral-leg access is captured in a register. Peripheral strobes begin in the cycle after the master presents the request. `m_stall` is high in every cycle from the request until the cycle in which `m_ack` is high, and low in that cycle.
- R5: If only byte selects [7:4] are active, the narrow cycle uses peripheral address bit 2 = 1, `io_sel` = sel[7:4] and `io_wdat` = wdat[63:32]. Otherwise the first narrow cycle uses bit 2 = 0, sel[3:0] and wdat[31:0].
- R6: If byte selects are active in both halves, two narrow cycles run one after the other. The low half goes first, and the high half starts only after the low half is acknowledged.
- R7: If a read touches one half, the 32-bit result appears on both halves of `m_rdat`. A split read returns the low-half result in [31:0] and the high-half result in [63:32].
- R8: The peripheral index is byte-address bits [14:12]. Index i < 5 raises only `io_cyc[i]`/`io_stb[i]`. `io_adr` carries byte-address bits [11:3], with bit 2 set by the half being accessed and bits [1:0] zero.
- R9: A narrow cycle whose peripheral index is 5 or more strobes no peripheral. It is acknowledged internally one clock after it starts, and its read data is all ones.
- R10: For the peripheral leg, `m_ack` goes high one clock after the last narrow cycle is acknowledged, and it is a single-cycle pulse.
- R11: During and right after reset, no target strobe, `m_ack` or `m_stall` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_cyc | input | 1 | Master cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | 32 | Master byte address |
| m_sel | input | 8 | Master byte selects |
| m_wdat | input | 64 | Master write data |
| m_rdat | output | 64 | Read data to master |
| m_ack | output | 1 | Acknowledge to master |
| m_stall | output | 1 | Stall to master |
| mem_adr | output | 32 | Shared memory address |
| mem_we | output | 1 | Shared memory write enable |
| mem_sel | output | 8 | Shared memory byte selects |
| mem_wdat | output | 64 | Shared memory write data |
| bram_cyc | output | 1 | Block RAM cycle |
| bram_stb | output | 1 | Block RAM strobe |
| bram_rdat | input | 64 | Block RAM read data |
| bram_ack | input | 1 | Block RAM acknowledge |
| dram_cyc | output | 1 | DRAM cycle |
| dram_stb | output | 1 | DRAM strobe |
| dram_rdat | input | 64 | DRAM read data |
| dram_ack | input | 1 | DRAM acknowledge |
| io_cyc | output | 5 | Per-peripheral cycle |
| io_stb | output | 5 | Per-peripheral strobe |
| io_we | output | 1 | Peripheral write enable |
| io_adr | output | 12 | Peripheral byte offset |
| io_sel | output | 4 | Peripheral byte selects |
| io_wdat | output | 32 | Peripheral write data |
| io_rdat | input | 160 | Peripheral read data, 32 bits per peripheral |
| io_ack | input | 5 | Per-peripheral acknowledge |

## Verification
The accesses cover every first-level region, including both edges of the unmapped region. Each first-level check compares read data and the number of clock edges before the acknowledge, which separates the combinational memory path, the registered DRAM model and the self-answered unmapped region. Peripheral accesses use selects for the low half only, the high half only, both full halves, and a partial pattern that straddles the 32-bit boundary. Latencies of three and five edges separate a single narrow cycle from a split one, and the lane placement of the read data shows whether results were replicated or merged. Writes are logged at the peripheral ports to confirm the half order, the selected peripheral, the offset, the selects and the data lane. An out-of-range peripheral index shows that the leg finishes without strobing any peripheral.

// File: rtl/bus_split_pkg.sv
package bus_split_pkg;
  // First-level destination, coded as the top two byte-address bits
  typedef enum logic [1:0] {
    TGT_BRAM = 2'b00,
    TGT_DRAM = 2'b01,
    TGT_NONE = 2'b10,
    TGT_IO   = 2'b11
  } tgt_e;

  // Peripheral-leg sequencer
  typedef enum logic [1:0] {
    LEG_IDLE,
    LEG_LO,
    LEG_HI,
    LEG_DONE
  } leg_e;
endpackage

// File: rtl/l1_router.sv
module l1_router
  import bus_split_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_cyc,
  input  logic          m_stb,
  input  logic [AW-1:0] m_adr,
  output logic [DW-1:0] m_rdat,
  output logic          m_ack,
  output logic          m_stall,
  output logic          bram_cyc,
  output logic          bram_stb,
  input  logic [DW-1:0] bram_rdat,
  input  logic          bram_ack,
  output logic          dram_cyc,
  output logic          dram_stb,
  input  logic [DW-1:0] dram_rdat,
  input  logic          dram_ack,
  output logic          leg_req,
  input  logic [DW-1:0] leg_rdat,
  input  logic          leg_ack,
  input  logic          leg_stall
);
  localparam int RMSB = AW - 1;
  localparam int RLSB = AW - 2;

  tgt_e tgt;
  logic none_req;
  logic none_ack_q, none_ack_d;

  assign tgt      = tgt_e'(m_adr[RMSB:RLSB]);
  assign bram_cyc = m_cyc && (tgt == TGT_BRAM);
  assign bram_stb = m_stb && (tgt == TGT_BRAM);
  assign dram_cyc = m_cyc && (tgt == TGT_DRAM);
  assign dram_stb = m_stb && (tgt == TGT_DRAM);
  assign leg_req  = m_cyc && m_stb && (tgt == TGT_IO);
  assign none_req = m_cyc && m_stb && (tgt == TGT_NONE);

  always_comb begin
    none_ack_d = none_req && !none_ack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) none_ack_q <= 1'b0;
    else        none_ack_q <= none_ack_d;
  end

  always_comb begin
    m_stall = 1'b0;
    unique case (tgt)
      TGT_BRAM: begin m_ack = bram_ack;   m_rdat = bram_rdat; end
      TGT_DRAM: begin m_ack = dram_ack;   m_rdat = dram_rdat; end
      TGT_IO:   begin m_ack = leg_ack;    m_rdat = leg_rdat; m_stall = leg_stall; end
      default:  begin m_ack = none_ack_q; m_rdat = '1; end
    endcase
  end

  // R1
  l1_single_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bram_stb, dram_stb, leg_req, none_req}));
  // R3
  l1_none_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    none_ack_q |=> !none_ack_q);
endmodule

// File: rtl/io_leg.sv
module io_leg
  import bus_split_pkg::*;
#(
  parameter int NP       = 5,
  parameter int PIDX_W   = 3,
  parameter int PSEL_LSB = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic [PSEL_LSB+PIDX_W-1:3] adr_i,
  input  logic [7:0]                 sel_i,
  input  logic                       we_i,
  input  logic [63:0]                wdat_i,
  output logic                       ack_o,
  output logic                       stall_o,
  output logic [63:0]                rdat_o,
  output logic [NP-1:0]              p_cyc_o,
  output logic [NP-1:0]              p_stb_o,
  output logic                       p_we_o,
  output logic [PSEL_LSB-1:0]        p_adr_o,
  output logic [3:0]                 p_sel_o,
  output logic [31:0]                p_wdat_o,
  input  logic [NP*32-1:0]           p_rdat_i,
  input  logic [NP-1:0]              p_ack_i
);
  localparam int OFF_W = PSEL_LSB - 3;

  leg_e                st_q, st_d;
  logic                lat_en;
  logic [PIDX_W-1:0]   idx_q;
  logic [OFF_W-1:0]    off_q;
  logic [7:0]          sel_q;
  logic                we_q;
  logic [63:0]         wdat_q;
  logic [31:0]         lo_q, lo_d;
  logic [63:0]         rd_q, rd_d;
  logic                un_ack_q, un_ack_d;
  logic                phase, hi_phase, idx_ok, ack_i;
  logic [31:0]         rd_i;
  logic                has_lo, has_hi;

  assign phase    = (st_q == LEG_LO) || (st_q == LEG_HI);
  assign hi_phase = (st_q == LEG_HI);
  assign idx_ok   = (int'(idx_q) < NP);
  assign has_lo   = |sel_q[3:0];
  assign has_hi   = |sel_q[7:4];

  // Second-level decode, one strobe per peripheral
  for (genvar i = 0; i < NP; i++) begin : g_l2
    assign p_cyc_o[i] = phase && (int'(idx_q) == i);
    assign p_stb_o[i] = phase && (int'(idx_q) == i);
  end

  always_comb begin
    ack_i = un_ack_q;
    rd_i  = '1;
    for (int i = 0; i < NP; i++) begin
      if (int'(idx_q) == i) begin
        ack_i = p_ack_i[i];
        rd_i  = p_rdat_i[i*32 +: 32];
      end
    end
  end

  assign p_we_o   = we_q;
  assign p_adr_o  = {off_q, hi_phase, 2'b00};
  assign p_sel_o  = hi_phase ? sel_q[7:4]    : sel_q[3:0];
  assign p_wdat_o = hi_phase ? wdat_q[63:32] : wdat_q[31:0];
  assign ack_o    = (st_q == LEG_DONE);
  assign rdat_o   = rd_q;
  assign stall_o  = phase || ((st_q == LEG_IDLE) && req_i);

  // Next state
  always_comb begin
    st_d     = st_q;
    lat_en   = 1'b0;
    lo_d     = lo_q;
    rd_d     = rd_q;
    un_ack_d = phase && !idx_ok && !un_ack_q;
    unique case (st_q)
      LEG_IDLE: if (req_i) begin
        lat_en = 1'b1;
        st_d   = ((|sel_i[3:0]) || !(|sel_i[7:4])) ? LEG_LO : LEG_HI;
      end
      LEG_LO: if (ack_i) begin
        lo_d = rd_i;
        rd_d = {rd_i, rd_i};
        st_d = has_hi ? LEG_HI : LEG_DONE;
      end
      LEG_HI: if (ack_i) begin
        rd_d = {rd_i, has_lo ? lo_q : rd_i};
        st_d = LEG_DONE;
      end
      default: st_d = LEG_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= LEG_IDLE;
      un_ack_q <= 1'b0;
      idx_q    <= '0;
      off_q    <= '0;
      sel_q    <= '0;
      we_q     <= 1'b0;
      wdat_q   <= '0;
      lo_q     <= '0;
      rd_q     <= '0;
    end else begin
      st_q     <= st_d;
      un_ack_q <= un_ack_d;
      lo_q     <= lo_d;
      rd_q     <= rd_d;
      if (lat_en) begin
        idx_q  <= adr_i[PSEL_LSB+PIDX_W-1:PSEL_LSB];
        off_q  <= adr_i[PSEL_LSB-1:3];
        sel_q  <= sel_i;
        we_q   <= we_i;
        wdat_q <= wdat_i;
      end
    end
  end

  // R8
  l2_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p_cyc_o));
  // R4
  leg_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|p_cyc_o) |-> $past(req_i));
  // R6
  split_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_phase) && $past(phase) |-> $past(ack_i));
  // R10
  leg_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
endmodule

// File: rtl/bus_splitter.sv
module bus_splitter #(
  parameter int AW       = 32,
  parameter int NP       = 5,
  parameter int PIDX_W   = 3,
  parameter int PSEL_LSB = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                m_cyc,
  input  logic                m_stb,
  input  logic                m_we,
  input  logic [AW-1:0]       m_adr,
  input  logic [7:0]          m_sel,
  input  logic [63:0]         m_wdat,
  output logic [63:0]         m_rdat,
  output logic                m_ack,
  output logic                m_stall,
  output logic [AW-1:0]       mem_adr,
  output logic                mem_we,
  output logic [7:0]          mem_sel,
  output logic [63:0]         mem_wdat,
  output logic                bram_cyc,
  output logic                bram_stb,
  input  logic [63:0]         bram_rdat,
  input  logic                bram_ack,
  output logic                dram_cyc,
  output logic                dram_stb,
  input  logic [63:0]         dram_rdat,
  input  logic                dram_ack,
  output logic [NP-1:0]       io_cyc,
  output logic [NP-1:0]       io_stb,
  output logic                io_we,
  output logic [PSEL_LSB-1:0] io_adr,
  output logic [3:0]          io_sel,
  output logic [31:0]         io_wdat,
  input  logic [NP*32-1:0]    io_rdat,
  input  logic [NP-1:0]       io_ack
);
  localparam int DW = 64;

  logic          leg_req, leg_ack, leg_stall;
  logic [DW-1:0] leg_rdat;

  assign mem_adr  = m_adr;
  assign mem_we   = m_we;
  assign mem_sel  = m_sel;
  assign mem_wdat = m_wdat;

  l1_router #(.AW(AW), .DW(DW)) u_l1 (
    .clk(clk), .rst_n(rst_n),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_adr(m_adr),
    .m_rdat(m_rdat), .m_ack(m_ack), .m_stall(m_stall),
    .bram_cyc(bram_cyc), .bram_stb(bram_stb), .bram_rdat(bram_rdat), .bram_ack(bram_ack),
    .dram_cyc(dram_cyc), .dram_stb(dram_stb), .dram_rdat(dram_rdat), .dram_ack(dram_ack),
    .leg_req(leg_req), .leg_rdat(leg_rdat), .leg_ack(leg_ack), .leg_stall(leg_stall)
  );

  io_leg #(.NP(NP), .PIDX_W(PIDX_W), .PSEL_LSB(PSEL_LSB)) u_leg (
    .clk(clk), .rst_n(rst_n),
    .req_i(leg_req), .adr_i(m_adr[PSEL_LSB+PIDX_W-1:3]), .sel_i(m_sel),
    .we_i(m_we), .wdat_i(m_wdat),
    .ack_o(leg_ack), .stall_o(leg_stall), .rdat_o(leg_rdat),
    .p_cyc_o(io_cyc), .p_stb_o(io_stb), .p_we_o(io_we), .p_adr_o(io_adr),
    .p_sel_o(io_sel), .p_wdat_o(io_wdat), .p_rdat_i(io_rdat), .p_ack_i(io_ack)
  );
endmodule

// File: tb/tb_bus_splitter.sv
`timescale 1ns/1ps
module tb_bus_splitter;
  localparam int NP = 5;
  localparam int NV = 12;
  localparam logic [63:0] WD = 64'h11223344_55667788;

  // {adr32, sel8, we1, chk1, lat4, rdat64}
  localparam logic [NV-1:0][109:0] VEC = '{
    {32'h0000_1238, 8'hFF, 1'b0, 1'b1, 4'd0, 64'hB0B0B0B0_00001238},
    {32'h4000_0100, 8'h0F, 1'b0, 1'b1, 4'd1, 64'hD0D0D0D0_40000100},
    {32'h8000_0000, 8'hFF, 1'b0, 1'b1, 4'd1, 64'hFFFFFFFF_FFFFFFFF},
    {32'hBFFF_FFF8, 8'h01, 1'b0, 1'b1, 4'd1, 64'hFFFFFFFF_FFFFFFFF},
    {32'hC000_2010, 8'h0F, 1'b0, 1'b1, 4'd3, 64'hA2000010_A2000010},
    {32'hC000_2010, 8'hF0, 1'b0, 1'b1, 4'd3, 64'hA2000014_A2000014},
    {32'hC000_1020, 8'hFF, 1'b0, 1'b1, 4'd5, 64'hA1000024_A1000020},
    {32'hC000_6008, 8'h0F, 1'b0, 1'b1, 4'd3, 64'hFFFFFFFF_FFFFFFFF},
    {32'hC000_4FF8, 8'hF0, 1'b0, 1'b1, 4'd3, 64'hA4000FFC_A4000FFC},
    {32'hC000_0040, 8'h3C, 1'b0, 1'b1, 4'd5, 64'hA0000044_A0000040},
    {32'h7FFF_FFF8, 8'h80, 1'b1, 1'b0, 4'd1, 64'h0},
    {32'h3FFF_FFF8, 8'h01, 1'b0, 1'b1, 4'd0, 64'hB0B0B0B0_3FFFFFF8}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic m_cyc, m_stb, m_we;
  logic [31:0] m_adr;
  logic [7:0] m_sel;
  logic [63:0] m_wdat, m_rdat;
  logic m_ack, m_stall;
  logic [31:0] mem_adr;
  logic mem_we;
  logic [7:0] mem_sel;
  logic [63:0] mem_wdat;
  logic bram_cyc, bram_stb, bram_ack, dram_cyc, dram_stb, dram_ack;
  logic [63:0] bram_rdat, dram_rdat;
  logic [NP-1:0] io_cyc, io_stb, io_ack;
  logic io_we;
  logic [11:0] io_adr;
  logic [3:0] io_sel;
  logic [31:0] io_wdat;
  logic [NP*32-1:0] io_rdat;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bus_splitter dut (
    .clk(clk), .rst_n(rst_n), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
    .m_adr(m_adr), .m_sel(m_sel), .m_wdat(m_wdat), .m_rdat(m_rdat),
    .m_ack(m_ack), .m_stall(m_stall), .mem_adr(mem_adr), .mem_we(mem_we),
    .mem_sel(mem_sel), .mem_wdat(mem_wdat), .bram_cyc(bram_cyc),
    .bram_stb(bram_stb), .bram_rdat(bram_rdat), .bram_ack(bram_ack),
    .dram_cyc(dram_cyc), .dram_stb(dram_stb), .dram_rdat(dram_rdat),
    .dram_ack(dram_ack), .io_cyc(io_cyc), .io_stb(io_stb), .io_we(io_we),
    .io_adr(io_adr), .io_sel(io_sel), .io_wdat(io_wdat), .io_rdat(io_rdat),
    .io_ack(io_ack)
  );

  // Target models
  assign bram_ack  = bram_cyc & bram_stb;
  assign bram_rdat = {32'hB0B0B0B0, mem_adr};
  assign dram_rdat = {32'hD0D0D0D0, mem_adr};
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dram_ack <= 1'b0;
    else        dram_ack <= dram_cyc & dram_stb & ~dram_ack;

  for (genvar i = 0; i < NP; i++) begin : g_per
    assign io_rdat[i*32 +: 32] = {4'hA, 4'(i), 12'h000, io_adr};
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) io_ack[i] <= 1'b0;
      else        io_ack[i] <= io_cyc[i] & io_stb[i] & ~io_ack[i];
  end

  // Log of completed narrow cycles, sampled mid-cycle
  int          log_n;
  int          log_idx [4];
  logic [11:0] log_adr [4];
  logic [3:0]  log_sel [4];
  logic [31:0] log_wd  [4];
  logic        log_we  [4];
  always @(negedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (io_cyc[i] && io_stb[i] && io_ack[i] && log_n < 4) begin
        log_idx[log_n] = i;
        log_adr[log_n] = io_adr;
        log_sel[log_n] = io_sel;
        log_wd[log_n]  = io_wdat;
        log_we[log_n]  = io_we;
        log_n = log_n + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One master access; called at a negedge
  task automatic access(input logic [31:0] a, input logic [7:0] s, input logic we,
                        output logic [63:0] rd, output int lat,
                        output bit stall_ok, output bit route_ok);
    logic [1:0] tg;
    tg = a[31:30];
    log_n = 0;
    stall_ok = 1'b1;
    route_ok = 1'b1;
    lat = 0;
    m_adr = a; m_sel = s; m_we = we; m_wdat = WD;
    m_cyc = 1'b1; m_stb = 1'b1;
    forever begin
      #1;
      if (bram_cyc !== (tg == 2'b00) || dram_cyc !== (tg == 2'b01)) route_ok = 1'b0;
      if (tg != 2'b11 && io_cyc !== '0) route_ok = 1'b0;
      if (m_ack === 1'b1) begin
        if (m_stall !== 1'b0) stall_ok = 1'b0;
        break;
      end
      if (m_stall !== (tg == 2'b11)) stall_ok = 1'b0;
      if (lat > 20) break;
      @(negedge clk);
      lat++;
    end
    rd = m_rdat;
    m_cyc = 1'b0; m_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] rd;
    int lat;
    bit s_ok, r_ok;
    m_cyc = 0; m_stb = 0; m_we = 0; m_adr = '0; m_sel = '0; m_wdat = '0;
    log_n = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 strobes in reset", {bram_cyc, dram_cyc, io_cyc, m_ack, m_stall}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 strobes after reset", {bram_stb, dram_stb, io_stb, m_ack, m_stall}, '0);

    // Table of accesses: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      access(VEC[v][109:78], VEC[v][77:70], VEC[v][69], rd, lat, s_ok, r_ok);
      chk($sformatf("R10/R3 latency vec%0d", v), 64'(lat), 64'(VEC[v][67:64]));
      if (VEC[v][68]) chk($sformatf("R7/R2 rdata vec%0d", v), rd, VEC[v][63:0]);
      chk($sformatf("R4 stall vec%0d", v), 64'(s_ok), 64'd1);
      chk($sformatf("R1 routing vec%0d", v), 64'(r_ok), 64'd1);
    end

    // R2 pass-through of request fields to DRAM
    m_adr = 32'h4000_0A08; m_sel = 8'h5A; m_we = 1'b1; m_wdat = WD;
    m_cyc = 1'b1; m_stb = 1'b1;
    #1;
    chk("R2 mem fields", {mem_adr, mem_sel, mem_we}, {32'h4000_0A08, 8'h5A, 1'b1});
    chk("R2 mem wdat", mem_wdat, WD);
    m_cyc = 1'b0; m_stb = 1'b0;
    repeat (3) @(negedge clk);

    // R6 R5 split write, low half first
    access(32'hC000_0000, 8'hFF, 1'b1, rd, lat, s_ok, r_ok);
    chk("R6 split write count", 64'(log_n), 64'd2);
    chk("R6 first half", {log_adr[0], log_sel[0], log_wd[0], log_we[0]},
        {12'h000, 4'hF, 32'h55667788, 1'b1});
    chk("R6 second half", {log_adr[1], log_sel[1], log_wd[1]},
        {12'h004, 4'hF, 32'h11223344});
    chk("R8 split peripheral", 64'(log_idx[1]), 64'd0);

    // R5 upper-only write
    access(32'hC000_3100, 8'hF0, 1'b1, rd, lat, s_ok, r_ok);
    chk("R5 upper count", 64'(log_n), 64'd1);
    chk("R5 upper fields", {log_adr[0], log_sel[0], log_wd[0]},
        {12'h104, 4'hF, 32'h11223344});
    chk("R8 upper peripheral", 64'(log_idx[0]), 64'd3);

    // R5 partial low-only write
    access(32'hC000_2008, 8'h0C, 1'b1, rd, lat, s_ok, r_ok);
    chk("R5 lower fields", {log_adr[0], log_sel[0], log_wd[0]},
        {12'h008, 4'hC, 32'h55667788});
    chk("R8 lower peripheral", 64'(log_idx[0]), 64'd2);

    // R9 unmapped peripheral write touches nothing
    access(32'hC000_5000, 8'h0F, 1'b1, rd, lat, s_ok, r_ok);
    chk("R9 no peripheral strobed", 64'(log_n), 64'd0);
    chk("R9 latency", 64'(lat), 64'd3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule